// File: doc/BRIEF.md
# Video Timing Master/Slave Controller

This block produces or follows the horizontal sync, vertical sync, blanking and field timing for a video encoder. In master operation it runs a pixel counter and a line counter that wrap at programmed totals. From their position it drives sync pulses, a blanking signal and a field flag. In slave operation it takes sync pulses from outside and realigns its counters to them. It also works out the field from where the vertical sync leading edge falls within the line.

Sync direction and blank direction are chosen separately, and each of the four timing pins has its own polarity bit. When blanking is generated internally, a select bit sets where the blanking deassertion falls relative to the pixel sampling strobe. With the bit clear, blanking leads the strobe by one pixel clock. With the bit set, both change in the same cycle. When blanking comes from outside, it is read in the same cycle as the pixel data. In embedded-code input mode, all external timing pins are ignored and the counters run freely.

Top module: `vid_timing_ctl`

## Requirements
- R1: While reset is held and right after it, hs_out and vs_out are at their inactive level, blank_out is at its active level, field_out shows field 0 and pix_sample is low.
- R2: In master timing, the pixel position h counts 0..h_total-1 and the line position v advances on each line wrap, modulo v_total. Hsync is active while h < h_sync_len and vsync is active while v < v_sync_len. Each sync pin shows the position held one clock earlier. After n clocks from reset release, the position is h = n mod h_total and v = (n div h_total) mod v_total.
- R3: A position is active when h >= h_total-h_active and v >= v_total-v_active. With internal blanking, pix_sample after n clocks equals the activity of position n-2.
- R4: With internal blanking, blank_out after n clocks shows the inactivity of position n-1 when blank_late=0. This is one clock ahead of pix_sample. With blank_late=1 it shows the inactivity of position n-2, in the same cycle as pix_sample.
- R5: Every timing pin level equals its active-high value XOR its polarity bit (1 = active low), for hsync, vsync, blank and field independently, on both outputs and inputs.
- R6: In master timing, the field flag toggles on each frame wrap. After n clocks it equals floor(n / (h_total*v_total)) mod 2.
- R7: In slave sync, a vsync leading edge sets the field to 1 when it arrives at least h_total/2 clocks after the last hsync leading edge, and to 0 otherwise. The field flag is unchanged between vsync edges.
- R8: With external blanking (blank_drive=0, code_mode=0), pix_sample is high in exactly the cycles in which blank_in is at its inactive level.
- R9: sync_oe equals sync_drive and blank_oe equals blank_drive, each independent of the other.
- R10: With code_mode=1, hs_in, vs_in and blank_in are ignored and all outputs follow the master timing of R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_drive | input | 1 | 1: block generates syncs; 0: follows hs_in/vs_in |
| blank_drive | input | 1 | 1: block generates blanking; 0: uses blank_in |
| code_mode | input | 1 | Embedded-code input: external timing pins ignored |
| blank_late | input | 1 | Blank deassertion aligned with pix_sample when 1, one clock earlier when 0 |
| pol_hs | input | 1 | Hsync polarity (1 = active low) |
| pol_vs | input | 1 | Vsync polarity (1 = active low) |
| pol_blank | input | 1 | Blank polarity (1 = active low) |
| pol_field | input | 1 | Field polarity (1 = inverted) |
| h_total | input | CW | Pixels per line |
| h_active | input | CW | Active pixels per line |
| h_sync_len | input | CW | Hsync width in pixels |
| v_total | input | CW | Lines per field |
| v_active | input | CW | Active lines per field |
| v_sync_len | input | CW | Vsync width in lines |
| hs_in | input | 1 | External hsync |
| vs_in | input | 1 | External vsync |
| blank_in | input | 1 | External blanking |
| hs_out | output | 1 | Generated hsync |
| vs_out | output | 1 | Generated vsync |
| blank_out | output | 1 | Generated blanking |
| field_out | output | 1 | Field indication, always driven |
| sync_oe | output | 1 | Drive enable for the sync pins |
| blank_oe | output | 1 | Drive enable for the blank pin |
| pix_sample | output | 1 | Pixel data is sampled in this cycle |

## Verification
In slave sync, the line restart caused by an hsync leading edge and the field capture caused by a vsync leading edge can happen in the same clock. They do when the two pins rise together. The bench drives vsync at offset 0 from hsync, as well as at offsets on both sides of half a line, under both vsync polarities. It judges the result by the field flag read a full line later. In master timing, the frame wrap toggles the field in the same cycle that blanking and vsync change. A per-cycle model of field, syncs and blanking checks all three together.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

  typedef enum logic {
    FLD_EVEN = 1'b0,
    FLD_ODD  = 1'b1
  } vtc_field_e;

  // position lies in the last `len` slots of a span of `total`
  function automatic logic tail_hit(input int unsigned pos, input int unsigned total,
                                    input int unsigned len);
    return (pos + len) >= total;
  endfunction

  // position lies in the first `len` slots
  function automatic logic head_hit(input int unsigned pos, input int unsigned len);
    return pos < len;
  endfunction

  // position is in the second half of the line
  function automatic logic past_half(input int unsigned pos, input int unsigned total);
    return pos >= (total >> 1);
  endfunction

endpackage

// File: rtl/vtc_sync_in.sv
module vtc_sync_in (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic lead
);
  logic act_q, act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      act_d <= 1'b0;
    end else begin
      act_q <= pin ^ pol;
      act_d <= act_q;
    end
  end

  assign lead = act_q & ~act_d;
endmodule

// File: rtl/vtc_counters.sv
module vtc_counters import vtc_pkg::*; #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          follow,
  input  logic [CW-1:0] h_total,
  input  logic [CW-1:0] v_total,
  input  logic          hs_edge,
  input  logic          vs_edge,
  output logic [CW-1:0] h_cnt,
  output logic [CW-1:0] v_cnt,
  output logic          line_end,
  output logic          frame_end
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic v_pend;
  logic vs_early, vs_late;

  assign line_end  = (h_cnt == h_total - ONE);
  assign frame_end = line_end && (v_cnt == v_total - ONE);
  assign vs_early  = follow & vs_edge & ~past_half(32'(h_cnt), 32'(h_total));
  assign vs_late   = follow & vs_edge &  past_half(32'(h_cnt), 32'(h_total));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
    end else if (follow && hs_edge) begin
      h_cnt <= ONE;
    end else if (line_end) begin
      h_cnt <= '0;
    end else begin
      h_cnt <= h_cnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_cnt  <= '0;
      v_pend <= 1'b0;
    end else if (vs_early) begin
      v_cnt  <= '0;
      v_pend <= 1'b0;
    end else if (line_end) begin
      v_cnt  <= (v_pend || vs_late || frame_end) ? '0 : v_cnt + ONE;
      v_pend <= 1'b0;
    end else if (vs_late) begin
      v_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/vtc_field.sv
module vtc_field import vtc_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_ev,
  input  logic cap_ev,
  input  logic cap_val,
  output logic field
);
  vtc_field_e fld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= FLD_EVEN;
    end else if (tgl_ev) begin
      fld_q <= (fld_q == FLD_EVEN) ? FLD_ODD : FLD_EVEN;
    end else if (cap_ev) begin
      fld_q <= cap_val ? FLD_ODD : FLD_EVEN;
    end
  end

  assign field = (fld_q == FLD_ODD);
endmodule

// File: rtl/vid_timing_ctl.sv
module vid_timing_ctl import vtc_pkg::*; #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_drive,
  input  logic          blank_drive,
  input  logic          code_mode,
  input  logic          blank_late,
  input  logic          pol_hs,
  input  logic          pol_vs,
  input  logic          pol_blank,
  input  logic          pol_field,
  input  logic [CW-1:0] h_total,
  input  logic [CW-1:0] h_active,
  input  logic [CW-1:0] h_sync_len,
  input  logic [CW-1:0] v_total,
  input  logic [CW-1:0] v_active,
  input  logic [CW-1:0] v_sync_len,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic          blank_in,
  output logic          hs_out,
  output logic          vs_out,
  output logic          blank_out,
  output logic          field_out,
  output logic          sync_oe,
  output logic          blank_oe,
  output logic          pix_sample
);
  // mode decode
  logic eff_master, follow, blank_int_src;
  assign eff_master    = sync_drive | code_mode;
  assign follow        = ~eff_master;
  assign blank_int_src = blank_drive | code_mode;
  assign sync_oe       = sync_drive;
  assign blank_oe      = blank_drive;

  // slave sync conditioning
  logic hs_lead, vs_lead, hs_edge, vs_edge;

  vtc_sync_in u_hs_in (.clk(clk), .rst_n(rst_n), .pin(hs_in), .pol(pol_hs), .lead(hs_lead));
  vtc_sync_in u_vs_in (.clk(clk), .rst_n(rst_n), .pin(vs_in), .pol(pol_vs), .lead(vs_lead));

  assign hs_edge = follow & hs_lead;
  assign vs_edge = follow & vs_lead;

  // position counters
  logic [CW-1:0] h_cnt, v_cnt;
  logic          line_end, frame_end;

  vtc_counters #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .follow(follow),
    .h_total(h_total), .v_total(v_total),
    .hs_edge(hs_edge), .vs_edge(vs_edge),
    .h_cnt(h_cnt), .v_cnt(v_cnt),
    .line_end(line_end), .frame_end(frame_end)
  );

  // window decode
  logic de_now, hs_now, vs_now;
  assign de_now = tail_hit(32'(h_cnt), 32'(h_total), 32'(h_active))
                & tail_hit(32'(v_cnt), 32'(v_total), 32'(v_active));
  assign hs_now = head_hit(32'(h_cnt), 32'(h_sync_len));
  assign vs_now = head_hit(32'(v_cnt), 32'(v_sync_len));

  // output stage
  logic de_d1, de_d2, hs_q, vs_q, blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_d1   <= 1'b0;
      de_d2   <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      blank_q <= 1'b1;
    end else begin
      de_d1   <= de_now;
      de_d2   <= de_d1;
      hs_q    <= hs_now;
      vs_q    <= vs_now;
      blank_q <= blank_late ? ~de_d1 : ~de_now;
    end
  end

  // field
  logic tgl_ev, cap_ev, cap_val, field;
  assign tgl_ev  = eff_master & frame_end;
  assign cap_ev  = vs_edge;
  assign cap_val = past_half(32'(h_cnt), 32'(h_total));

  vtc_field u_field (
    .clk(clk), .rst_n(rst_n), .tgl_ev(tgl_ev), .cap_ev(cap_ev),
    .cap_val(cap_val), .field(field)
  );

  assign hs_out     = hs_q ^ pol_hs;
  assign vs_out     = vs_q ^ pol_vs;
  assign blank_out  = blank_q ^ pol_blank;
  assign field_out  = field ^ pol_field;
  assign pix_sample = blank_int_src ? de_d2 : ~(blank_in ^ pol_blank);
endmodule

// File: rtl/vtc_checker.sv
module vtc_checker #(
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eff_master,
  input logic          blank_int_src,
  input logic          blank_late,
  input logic [CW-1:0] h_cnt,
  input logic [CW-1:0] h_total,
  input logic          hs_q,
  input logic          blank_q,
  input logic          pix_sample,
  input logic          tgl_ev,
  input logic          cap_ev,
  input logic          field
);
  p_hcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h_cnt < h_total);

  p_hs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_master && $rose(hs_q)) |-> (h_cnt == CW'(1)));

  p_blank_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_int_src && !blank_late && $fell(blank_q)) |=> pix_sample);

  p_blank_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_int_src && blank_late && $fell(blank_q)) |-> pix_sample);

  p_field_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_ev |=> (field != $past(field)));

  p_field_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tgl_ev || cap_ev) |=> $stable(field));
endmodule

bind vid_timing_ctl vtc_checker #(.CW(CW)) u_vtc_chk (
  .clk(clk), .rst_n(rst_n), .eff_master(eff_master), .blank_int_src(blank_int_src),
  .blank_late(blank_late), .h_cnt(h_cnt), .h_total(h_total), .hs_q(hs_q),
  .blank_q(blank_q), .pix_sample(pix_sample), .tgl_ev(tgl_ev), .cap_ev(cap_ev),
  .field(field)
);

// File: tb/vid_timing_ctl_tb_top.sv
`timescale 1ns/1ps
module vid_timing_ctl_tb_top;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic sync_drive, blank_drive, code_mode, blank_late;
  logic pol_hs, pol_vs, pol_blank, pol_field;
  logic hs_in, vs_in, blank_in;
  logic hs_out, vs_out, blank_out, field_out, sync_oe, blank_oe, pix_sample;
  int ht, ha, hsl, vt, va, vsl;

  vid_timing_ctl #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_drive(sync_drive), .blank_drive(blank_drive),
    .code_mode(code_mode), .blank_late(blank_late), .pol_hs(pol_hs), .pol_vs(pol_vs),
    .pol_blank(pol_blank), .pol_field(pol_field),
    .h_total(CW'(ht)), .h_active(CW'(ha)), .h_sync_len(CW'(hsl)),
    .v_total(CW'(vt)), .v_active(CW'(va)), .v_sync_len(CW'(vsl)),
    .hs_in(hs_in), .vs_in(vs_in), .blank_in(blank_in),
    .hs_out(hs_out), .vs_out(vs_out), .blank_out(blank_out), .field_out(field_out),
    .sync_oe(sync_oe), .blank_oe(blank_oe), .pix_sample(pix_sample)
  );

  int n_chk = 0;
  int n_err = 0;
  int vs_hold = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model of the position after g clocks
  function automatic bit m_act(input int g);
    int h, v;
    if (g < 0) return 1'b0;
    h = g % ht;
    v = (g / ht) % vt;
    return (h >= ht - ha) && (v >= vt - va);
  endfunction

  function automatic bit m_hs(input int g);
    if (g < 0) return 1'b0;
    return (g % ht) < hsl;
  endfunction

  function automatic bit m_vs(input int g);
    if (g < 0) return 1'b0;
    return ((g / ht) % vt) < vsl;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_master(input int n, input string ex);
    bit eb;
    eb = blank_late ? !m_act(n - 2) : !m_act(n - 1);
    chk(hs_out == (m_hs(n - 1) ^ pol_hs), {"R2 R5 hsync", ex}, int'(hs_out), int'(m_hs(n - 1) ^ pol_hs));
    chk(vs_out == (m_vs(n - 1) ^ pol_vs), {"R2 R5 vsync", ex}, int'(vs_out), int'(m_vs(n - 1) ^ pol_vs));
    chk(pix_sample == m_act(n - 2), {"R3 sample", ex}, int'(pix_sample), int'(m_act(n - 2)));
    chk(blank_out == (eb ^ pol_blank), {"R4 R5 blank", ex}, int'(blank_out), int'(eb ^ pol_blank));
    chk(field_out == (bit'((n / (ht * vt)) % 2) ^ pol_field), {"R6 field", ex},
        int'(field_out), int'(bit'((n / (ht * vt)) % 2) ^ pol_field));
  endtask

  task automatic run_master(input int frames, input bit scramble, input string ex);
    do_reset();
    chk(hs_out == pol_hs && vs_out == pol_vs, "R1 syncs idle", int'({hs_out, vs_out}), int'({pol_hs, pol_vs}));
    chk(blank_out == !pol_blank, "R1 blank active", int'(blank_out), int'(!pol_blank));
    chk(field_out == pol_field && pix_sample == 1'b0, "R1 field/sample", int'({field_out, pix_sample}), int'({pol_field, 1'b0}));
    chk(sync_oe == sync_drive && blank_oe == blank_drive, "R9 directions",
        int'({sync_oe, blank_oe}), int'({sync_drive, blank_drive}));
    for (int n = 1; n <= frames * ht * vt + 3; n++) begin
      if (scramble) begin
        hs_in = 1'($urandom);
        vs_in = 1'($urandom);
        blank_in = 1'($urandom);
      end
      @(posedge clk);
      @(negedge clk);
      check_master(n, ex);
    end
  endtask

  task automatic slave_line(input int d);
    for (int c = 0; c < ht; c++) begin
      if (c == d) vs_hold = 4;
      hs_in = (c < 2) ^ pol_hs;
      vs_in = (vs_hold > 0) ^ pol_vs;
      if (vs_hold > 0) vs_hold--;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic run_slave_field(input bit vpol);
    int offs[10];
    offs = '{0, 12, 5, 10, 9, 19, 0, 1, 15, 7};
    sync_drive = 1'b0; blank_drive = 1'b1; code_mode = 1'b0;
    pol_hs = ~vpol; pol_vs = vpol; pol_field = 1'b0; blank_late = 1'b0;
    ht = 20; ha = 12; hsl = 3; vt = 8; va = 5; vsl = 2;
    hs_in = pol_hs; vs_in = pol_vs;
    vs_hold = 0;
    do_reset();
    repeat (3) slave_line(-1);
    for (int i = 0; i < 12; i++) begin
      int d;
      d = (i < 10) ? offs[i] : int'($urandom % 20);
      slave_line(d);
      slave_line(-1);
      chk(field_out == (d >= ht / 2), $sformatf("R7 field offset %0d", d), int'(field_out), int'(d >= ht / 2));
      slave_line(-1);
      chk(field_out == (d >= ht / 2), "R7 field held", int'(field_out), int'(d >= ht / 2));
    end
  endtask

  task automatic run_slave_blank();
    sync_drive = 1'b1; blank_drive = 1'b0; code_mode = 1'b0;
    ht = 16; ha = 10; hsl = 2; vt = 6; va = 4; vsl = 1;
    for (int p = 0; p < 2; p++) begin
      pol_blank = p[0];
      do_reset();
      chk(sync_oe == 1'b1 && blank_oe == 1'b0, "R9 independent directions", int'({sync_oe, blank_oe}), 2);
      for (int k = 0; k < 40; k++) begin
        blank_in = 1'($urandom);
        #1;
        chk(pix_sample == !(blank_in ^ pol_blank), "R8 R5 external blank", int'(pix_sample),
            int'(!(blank_in ^ pol_blank)));
        @(negedge clk);
      end
    end
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'd1234));
    sync_drive = 1'b1; blank_drive = 1'b1; code_mode = 1'b0; blank_late = 1'b0;
    pol_hs = 1'b0; pol_vs = 1'b0; pol_blank = 1'b0; pol_field = 1'b0;
    hs_in = 1'b0; vs_in = 1'b0; blank_in = 1'b0;
    ht = 20; ha = 12; hsl = 3; vt = 8; va = 5; vsl = 2;

    // directed master runs, both blank alignments
    run_master(2, 1'b0, "");
    blank_late = 1'b1;
    pol_hs = 1'b1; pol_field = 1'b1;
    run_master(2, 1'b0, "");

    // random master configurations
    for (int r = 0; r < 5; r++) begin
      ht = 16 + int'($urandom % 17);
      ha = 1 + int'($urandom % (ht - 4));
      hsl = 1 + int'($urandom % 4);
      vt = 4 + int'($urandom % 9);
      va = 1 + int'($urandom % (vt - 1));
      vsl = 1 + int'($urandom % 3);
      blank_late = 1'($urandom);
      pol_hs = 1'($urandom); pol_vs = 1'($urandom);
      pol_blank = 1'($urandom); pol_field = 1'($urandom);
      run_master(2, 1'b0, "");
    end

    // embedded-code mode: pins scrambled and ignored
    sync_drive = 1'b0; blank_drive = 1'b0; code_mode = 1'b1;
    ht = 18; ha = 11; hsl = 2; vt = 6; va = 4; vsl = 1;
    blank_late = 1'b0; pol_vs = 1'b1;
    run_master(2, 1'b1, " R10");
    code_mode = 1'b0;

    run_slave_field(1'b0);
    run_slave_field(1'b1);
    run_slave_blank();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule